// File: doc/BRIEF.md
# Multi-Mode Histogram and Accumulating Buffer

This block is a 1024-word by 24-bit storage engine that has eight operating modes. A 3-bit function code selects the mode. The code is captured when a load strobe rises. An active-low start input then decides, cycle by cycle, whether each sampled pixel/data pair is processed.

In the counting modes the pixel bus addresses a bin. The bin is either incremented by one or has the data input added to it. The lookup-table modes write the data input into a word, or return a word on the data output. The delay modes use the bottom of the array as a circular buffer. They return either the sample from a fixed number of valid cycles earlier, or the current sample minus that delayed sample.

Two host modes give a processor access through strobes. One mode moves full 24-bit words. The other moves 16-bit halves chosen by an upper-half select. A flash clear input zeroes the whole array and the data path at once, with no clock needed.

Top module: `histo_buf`

## Requirements
- R1: The function code is captured on a rising edge of `fn_load`, and only pixels sampled on later clock edges use the new code. The codes are: 0 histogram, 1 bin accumulate, 2 table write, 3 table read, 4 delay, 5 delay-subtract, 6 host 24-bit, 7 host 16-bit. Changing `fn` without a `fn_load` edge has no effect.
- R2: In histogram mode, every clock edge that samples `start_n` low adds one to the word addressed by `pix`. Back-to-back samples of the same pixel each count, and the count wraps modulo 2^24.
- R3: In bin-accumulate mode, every sample taken with `start_n` low adds `din` to the word addressed by `pix`, modulo 2^24.
- R4: In table-write mode, a sample taken with `start_n` low stores `din` into the word addressed by `pix`.
- R5: In table-read mode, and in modes 0 to 2 when `start_n` is sampled high, `dout` shows the word addressed by `pix` after the second rising edge following the sample.
- R6: In delay mode, each sample taken with `start_n` low gives `dout` equal to the `din` of the valid sample DLY samples earlier, which is zero after a flash clear. The result appears after the second rising edge.
- R7: In delay-subtract mode, each sample taken with `start_n` low gives `dout` equal to the current `din` minus the sample DLY valid samples earlier, modulo 2^24.
- R8: While `flash_clr` is high, every word, the input registers, the delay pointer and `dout` are zero, without waiting for a clock edge. A sample held in the input registers when the clear arrives is dropped.
- R9: In host 24-bit mode, a falling edge of `host_wr_n` or `host_rd_n` captures `host_addr`. A rising edge of `host_wr_n` then stores `host_wdata`. While `host_rd_n` is low, `host_rdata` shows the captured word one edge after the fall.
- R10: In host 16-bit mode, `host_upper` high maps host bits 7:0 onto word bits 23:16. `host_upper` low maps host bits 15:0 onto word bits 15:0. Reads return the selected part, zero-extended, and a write leaves the other part of the word unchanged.
- R11: In host modes, the pixel bus and `start_n` have no effect: `dout` holds its value and the array is not changed by them.
- R12: `host_oe` equals the inverse of `host_rd_n` in every mode. Outside the host modes, `host_rdata` carries `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the mode and host strobe state |
| flash_clr | input | 1 | Asynchronous clear of the array and data path |
| pix | input | 10 | Pixel / bin address |
| din | input | 24 | Data input |
| fn | input | 3 | Function code |
| fn_load | input | 1 | Function code load strobe (rising edge) |
| start_n | input | 1 | Active-low sample enable |
| host_addr | input | 10 | Host word address |
| host_wdata | input | 24 | Host write data |
| host_upper | input | 1 | Upper-part select in 16-bit host mode |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe / output enable, active low |
| host_rdata | output | 24 | Host read data |
| host_oe | output | 1 | Host bus output enable |
| dout | output | 24 | Data output |

## Verification
The counting path is driven three ways:
- Runs of the same pixel on consecutive cycles check that back-to-back updates to one bin are all kept.
- Scattered pixels check that each bin is addressed separately.
- A bin preset to the all-ones value checks that the count wraps.

Bin accumulation is checked with an addend that carries past bit 23. The delay paths receive a stream longer than the buffer, which separates the zero-filled start from true delayed samples and shows whether the delay is off by one. A flash clear in the middle of a histogram run, and pixel activity during a host mode, show whether stray samples reach the array.

// File: rtl/histo_buf.sv
module histo_buf #(
  parameter int AW  = 10,
  parameter int DW  = 24,
  parameter int DLY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flash_clr,
  input  logic [AW-1:0] pix,
  input  logic [DW-1:0] din,
  input  logic [2:0]    fn,
  input  logic          fn_load,
  input  logic          start_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_upper,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  output logic [DW-1:0] host_rdata,
  output logic          host_oe,
  output logic [DW-1:0] dout
);
  localparam int WORDS = 1 << AW;
  localparam int PW    = $clog2(DLY);
  localparam logic [DW-1:0] ONE = 1;

  typedef enum logic [2:0] {
    M_HIST, M_ACC, M_LWR, M_LRD, M_DLY, M_DSUB, M_H24, M_H16
  } mode_t;

  mode_t mode, m_q;
  logic ld_q, wr_q, rd_q, act_q;
  logic [AW-1:0] hadr, p_q;
  logic [DW-1:0] d_q;
  logic [PW-1:0] ptr;
  logic [DW-1:0] mem [WORDS];

  wire host_mode = (mode == M_H24) || (mode == M_H16);
  wire host_we   = host_mode && !wr_q && host_wr_n;
  wire [AW-1:0] dly_a = AW'(ptr);
  wire [DW-1:0] dly_v = mem[dly_a];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_HIST;
      ld_q <= 1'b0;
      wr_q <= 1'b1;
      rd_q <= 1'b1;
      hadr <= '0;
    end else begin
      ld_q <= fn_load;
      wr_q <= host_wr_n;
      rd_q <= host_rd_n;
      if (fn_load && !ld_q) mode <= mode_t'(fn);
      if ((wr_q && !host_wr_n) || (rd_q && !host_rd_n)) hadr <= host_addr;
    end
  end

  always_ff @(posedge clk or posedge flash_clr) begin
    if (flash_clr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      p_q   <= '0;
      d_q   <= '0;
      act_q <= 1'b0;
      m_q   <= M_HIST;
      ptr   <= '0;
      dout  <= '0;
    end else begin
      p_q   <= pix;
      d_q   <= din;
      act_q <= !start_n;
      m_q   <= mode;
      case (m_q)
        M_HIST: if (act_q) mem[p_q] <= mem[p_q] + ONE; else dout <= mem[p_q];
        M_ACC:  if (act_q) mem[p_q] <= mem[p_q] + d_q; else dout <= mem[p_q];
        M_LWR:  if (act_q) mem[p_q] <= d_q;            else dout <= mem[p_q];
        M_LRD:  dout <= mem[p_q];
        M_DLY, M_DSUB:
          if (act_q) begin
            dout <= (m_q == M_DSUB) ? d_q - dly_v : dly_v;
            mem[dly_a] <= d_q;
            ptr <= (ptr == PW'(DLY - 1)) ? '0 : ptr + 1'b1;
          end
        default: ;
      endcase
      if (host_we) begin
        if (mode == M_H16) begin
          if (host_upper) mem[hadr][DW-1:16] <= host_wdata[DW-17:0];
          else            mem[hadr][15:0]    <= host_wdata[15:0];
        end else begin
          mem[hadr] <= host_wdata;
        end
      end
    end
  end

  assign host_oe = !host_rd_n;
  always_comb begin
    if (!host_mode)         host_rdata = dout;
    else if (mode == M_H24) host_rdata = mem[hadr];
    else if (host_upper)    host_rdata = DW'(mem[hadr][DW-1:16]);
    else                    host_rdata = DW'(mem[hadr][15:0]);
  end

  assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_load && !ld_q) |=> (mode == mode_t'($past(fn))));

  assert_hist_incr_R2: assert property (@(posedge clk) disable iff (!rst_n || flash_clr)
    (m_q == M_HIST && act_q && !host_we) |=> (mem[$past(p_q)] == $past(mem[p_q]) + ONE));

  assert_lut_write_R4: assert property (@(posedge clk) disable iff (!rst_n || flash_clr)
    (m_q == M_LWR && act_q && !host_we) |=> (mem[$past(p_q)] == $past(d_q)));

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ptr) < DLY));

  assert_flash_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_clr |-> (dout == '0 && !act_q));

  assert_host_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || flash_clr)
    (m_q == M_H24 || m_q == M_H16) |=> $stable(dout));
endmodule

// File: tb/histo_buf_bench.sv
module histo_buf_bench;
  localparam int DLY = 16;
  localparam int NS  = DLY + 6;

  logic clk = 1'b0;
  logic rst_n, flash_clr, fn_load, start_n, host_upper, host_wr_n, host_rd_n;
  logic [9:0]  pix, host_addr;
  logic [23:0] din, host_wdata, host_rdata, dout;
  logic [2:0]  fn;
  logic        host_oe;

  logic [23:0] model [1024];
  logic [23:0] vals [NS];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  histo_buf #(.AW(10), .DW(24), .DLY(DLY)) u_histo_buf (
    .clk, .rst_n, .flash_clr, .pix, .din, .fn, .fn_load, .start_n,
    .host_addr, .host_wdata, .host_upper, .host_wr_n, .host_rd_n,
    .host_rdata, .host_oe, .dout
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] c);
    @(negedge clk); start_n = 1'b1; fn = c; fn_load = 1'b1;
    @(negedge clk); fn_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic pix_op(input logic [9:0] p, input logic [23:0] d, input logic [2:0] m);
    @(negedge clk); pix = p; din = d; start_n = 1'b0;
    case (m)
      3'd0: model[p] = model[p] + 24'd1;
      3'd1: model[p] = model[p] + d;
      3'd2: model[p] = d;
      default: ;
    endcase
  endtask

  task automatic idle();
    @(negedge clk); start_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lut_read(input logic [9:0] p, input string tag);
    @(negedge clk); pix = p; start_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(tag, dout, model[p]);
  endtask

  task automatic host_write(input logic [9:0] a, input logic [23:0] w, input logic up);
    @(negedge clk); host_addr = a; host_wdata = w; host_upper = up; host_wr_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_read(input logic [9:0] a, input logic up, input logic [23:0] exp, input string tag);
    @(negedge clk); host_addr = a; host_upper = up; host_rd_n = 1'b0;
    @(negedge clk);
    chk(tag, host_rdata, exp);
    host_rd_n = 1'b1;
  endtask

  task automatic flash();
    @(negedge clk); flash_clr = 1'b1;
    for (int i = 0; i < 1024; i++) model[i] = '0;
    @(negedge clk); flash_clr = 1'b0; start_n = 1'b1;
  endtask

  task automatic stream(input bit sub, input string tag);
    for (int k = 0; k < NS + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        logic [23:0] old;
        old = (k - 2 >= DLY) ? vals[k-2-DLY] : 24'd0;
        chk(tag, dout, sub ? vals[k-2] - old : old);
      end
      if (k < NS) begin din = vals[k]; start_n = 1'b0; end
      else start_n = 1'b1;
    end
  endtask

  initial begin
    rst_n = 0; flash_clr = 1; fn_load = 0; start_n = 1; fn = 0;
    host_wr_n = 1; host_rd_n = 1; host_upper = 0; pix = 0; din = 0;
    host_addr = 0; host_wdata = 0;
    for (int i = 0; i < 1024; i++) model[i] = '0;
    for (int i = 0; i < NS; i++) vals[i] = 24'(i * 24'h13579 + 24'h000031);
    repeat (3) @(negedge clk);
    rst_n = 1; flash_clr = 0;
    @(negedge clk);
    chk("R8 reset dout", dout, 24'd0);
    chk("R12 reset oe", {23'd0, host_oe}, 24'd0);
    chk("R12 reset rdata", host_rdata, 24'd0);

    pix_op(10'd5, 0, 0); pix_op(10'd5, 0, 0); pix_op(10'd5, 0, 0); pix_op(10'd9, 0, 0);
    idle();
    lut_read(10'd5, "R2 back-to-back");
    lut_read(10'd9, "R2 single");
    lut_read(10'd6, "R5 untouched bin");

    fn = 3'd2;
    pix_op(10'd9, 24'h000055, 0);
    idle();
    lut_read(10'd9, "R1 no load edge");

    set_mode(3'd2);
    pix_op(10'd20, 24'hFFFFFF, 2); pix_op(10'd21, 24'd100, 2); pix_op(10'd22, 24'hABCDEF, 2);
    idle();
    lut_read(10'd20, "R4 write ones");
    lut_read(10'd22, "R4 write pattern");

    set_mode(3'd1);
    pix_op(10'd21, 24'd50, 1); pix_op(10'd21, 24'hFFFFF0, 1);
    idle();
    lut_read(10'd21, "R3 accumulate wrap");

    set_mode(3'd0);
    pix_op(10'd20, 0, 0);
    idle();
    lut_read(10'd20, "R2 wrap");

    set_mode(3'd3);
    @(negedge clk); pix = 10'd22; start_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 read with start low", dout, model[22]);
    start_n = 1'b1; host_rd_n = 1'b0;
    @(negedge clk);
    chk("R12 oe", {23'd0, host_oe}, 24'd1);
    chk("R12 rdata is dout", host_rdata, model[22]);
    host_rd_n = 1'b1;

    set_mode(3'd6);
    pix_op(10'd22, 24'd7, 6); pix_op(10'd23, 24'd7, 6); pix_op(10'd22, 24'd7, 6);
    idle();
    chk("R11 dout held", dout, model[22]);
    host_read(10'd22, 1'b0, model[22], "R11 word unchanged");
    host_write(10'd100, 24'h123456, 1'b0); model[100] = 24'h123456;
    host_write(10'd101, 24'h0F0F0F, 1'b0); model[101] = 24'h0F0F0F;
    host_read(10'd100, 1'b0, model[100], "R9 word 100");
    host_read(10'd101, 1'b0, model[101], "R9 word 101");

    set_mode(3'd7);
    host_write(10'd100, 24'h00BEEF, 1'b0);
    host_write(10'd100, 24'h0000A5, 1'b1); model[100] = 24'hA5BEEF;
    host_read(10'd100, 1'b1, 24'h0000A5, "R10 upper read");
    host_read(10'd100, 1'b0, 24'h00BEEF, "R10 lower read");
    set_mode(3'd6);
    host_read(10'd100, 1'b0, model[100], "R10 merged word");

    set_mode(3'd0);
    pix_op(10'd30, 0, 0); pix_op(10'd30, 0, 0);
    flash();
    lut_read(10'd30, "R8 bin after clear");
    lut_read(10'd22, "R8 table after clear");
    pix_op(10'd30, 0, 0);
    idle();
    lut_read(10'd30, "R2 count after clear");

    flash();
    set_mode(3'd4);
    stream(1'b0, "R6 delay");
    flash();
    set_mode(3'd5);
    stream(1'b1, "R7 delay-subtract");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule